// File: doc/BRIEF.md
# Frame Table Sequencer

This block walks a sixteen-entry table of frame instructions. Each entry names a line sequence for an external line executor, says how many times to run it, says how an external vertical-sync input (VD) may redirect the flow, and carries enable bits that gate the clamp, pixel-blanking, converter clock and amplifier outputs while the entry is active. The sequencer asks the line executor to run one line sequence and waits for it to report completion. Only then does it decide whether to repeat the same entry, jump to the entry's destination address, move to the next address or stop.

VD is synchronised on entry and latched while a line sequence runs. A VD pulse that is shorter than a line is still acted on, but the jump never cuts a line short. A table can keep repeating a preview entry until VD arrives, and then fall through to an integrate and readout sequence.

Top module: `ftab_seq`

## Requirements
- R1: After reset the table holds all zeros and the sequencer is idle: lt_start_o, lt_sel_o and all five control outputs are 0.
- R2: A cycle with tbl_wr_i high stores tbl_wdata_i at tbl_waddr_i. The entry layout is: repeat count [23:16], VD mode [15:14], destination [13:10], line select [9:6], clamp-OB enable bit 5, clamp-DM enable bit 4, blanking enable bit 3, blanking idle level bit 2, converter clock enable bit 1, amplifier bit 0.
- R3: start_i, when sampled high while idle, loads the entry at start_addr_i, and lt_start_o is high for the whole next cycle. Every line sequence is requested by exactly one single-cycle lt_start_o pulse, and lt_sel_o shows the line select of the active entry.
- R4: An entry with repeat count c runs c+1 line sequences. In VD mode 0 the sequencer then moves to the next address, with address 15 wrapping to 0.
- R5: In VD modes 0 and 3, VD has no effect on the flow.
- R6: In VD mode 1 the entry repeats without limit until a latched VD is found at a line boundary. Execution then continues at the entry's destination.
- R7: In VD mode 2, a latched VD at a line boundary jumps to the destination. Without VD, the entry runs c+1 lines and then moves to the next address.
- R8: VD is active high and passes through two synchronising flops. It is latched in any cycle spent waiting for lt_done_i. A jump happens only after lt_done_i, and the latch is cleared at every line boundary.
- R9: In VD mode 3 the entry runs c+1 lines and the sequencer then returns to idle. All control outputs go to 0 and a new start_i is accepted.
- R10: While an entry is active, clpob_o equals clpob_i AND its clamp-OB enable, and clpdm_o equals clpdm_i AND its clamp-DM enable. When no entry is active, both are 0.
- R11: pblk_o follows pblk_i when the active entry's blanking enable is 1. Otherwise it holds that entry's idle-level bit.
- R12: afe_clk_en_o and amp_en_o equal the active entry's converter clock and amplifier bits.
- R13: start_i has no effect while a table run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_i | input | 1 | Table write strobe |
| tbl_waddr_i | input | 4 | Table write address |
| tbl_wdata_i | input | 24 | Table entry to write |
| start_i | input | 1 | Start a table run from idle |
| start_addr_i | input | 4 | First entry of a run |
| vd_i | input | 1 | Asynchronous vertical sync, active high |
| lt_done_i | input | 1 | Line executor reports the sequence finished |
| lt_start_o | output | 1 | Request one line sequence |
| lt_sel_o | output | 4 | Line sequence to run |
| clpob_i | input | 1 | Optical-black clamp from general setup |
| clpdm_i | input | 1 | Dummy-pixel clamp from general setup |
| pblk_i | input | 1 | Pixel blanking from general setup |
| clpob_o | output | 1 | Gated optical-black clamp |
| clpdm_o | output | 1 | Gated dummy-pixel clamp |
| pblk_o | output | 1 | Gated blanking or idle level |
| afe_clk_en_o | output | 1 | Front-end converter and sample clock enable |
| amp_en_o | output | 1 | Output amplifier enable |

## Verification
The bench builds the block with the package defaults: a 16-entry table, an 8-bit repeat count and a 4-bit line select. With these values the address wrap from entry 15 to entry 0 and the destination field's full address range both occur in short runs. The line executor model is run with line lengths of one to six cycles. This lets VD pulses shorter than a line, VD held high across several entries, and VD arriving during the boundary cycles all be exercised against the reference model.

// File: rtl/ftab_pkg.sv
package ftab_pkg;

    localparam int FT_ADDR_W = 4;
    localparam int FT_DEPTH  = 1 << FT_ADDR_W;
    localparam int FT_CNT_W  = 8;
    localparam int FT_SEL_W  = 4;

    typedef enum logic [1:0] {
        VM_NEXT  = 2'd0,
        VM_WAIT  = 2'd1,
        VM_EARLY = 2'd2,
        VM_STOP  = 2'd3
    } vd_mode_e;

    typedef struct packed {
        logic [FT_CNT_W-1:0]  reps;
        vd_mode_e             mode;
        logic [FT_ADDR_W-1:0] dest;
        logic [FT_SEL_W-1:0]  sel;
        logic                 ob_en;
        logic                 dm_en;
        logic                 pb_en;
        logic                 pb_idle;
        logic                 afe_en;
        logic                 amp_on;
    } ft_entry_t;

    localparam int FT_ENTRY_W = $bits(ft_entry_t);

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_WAIT  = 2'd2,
        S_NEXT  = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        D_REPEAT,
        D_BRANCH,
        D_ADVANCE,
        D_HALT
    } seq_dec_e;

    typedef struct packed {
        logic clpob;
        logic clpdm;
        logic pblk;
        logic afe_clk;
        logic amp;
    } ctl_out_t;

    function automatic logic vd_sensitive(input vd_mode_e m);
        return (m == VM_WAIT) || (m == VM_EARLY);
    endfunction

    function automatic logic [FT_ADDR_W-1:0] step_addr(input logic [FT_ADDR_W-1:0] a);
        return a + FT_ADDR_W'(1);
    endfunction

endpackage

// File: rtl/ftab_store.sv
module ftab_store
    import ftab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [FT_ADDR_W-1:0] wr_addr,
    input  ft_entry_t            wr_data,
    input  logic [FT_ADDR_W-1:0] rd_addr,
    output ft_entry_t            rd_data
);

    ft_entry_t mem_q [FT_DEPTH];

    generate
        for (genvar i = 0; i < FT_DEPTH; i++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem_q[i] <= '0;
                end else if (wr_en && (wr_addr == FT_ADDR_W'(i))) begin
                    mem_q[i] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/ftab_vdsync.sv
module ftab_vdsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vd_i,
    output logic vd_s
);

    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-2:0], vd_i};
        end
    end

    assign vd_s = sh_q[STAGES-1];

endmodule

// File: rtl/ftab_ctrl.sv
module ftab_ctrl
    import ftab_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [FT_ADDR_W-1:0] start_addr_i,
    input  logic                 lt_done_i,
    input  logic                 vd_s,
    output logic [FT_ADDR_W-1:0] fetch_addr_o,
    input  ft_entry_t            fetch_ent_i,
    output seq_state_e           state_o,
    output ft_entry_t            act_o,
    output logic                 vd_flag_o,
    output logic                 lt_start_o
);

    seq_state_e           st_q;
    ft_entry_t            act_q;
    logic [FT_ADDR_W-1:0] addr_q;
    logic [FT_CNT_W-1:0]  rem_q;
    logic                 flag_q;

    seq_dec_e dec;
    logic     sens;
    logic     last;

    always_comb begin
        sens = vd_sensitive(act_q.mode);
        last = (rem_q == '0);
        dec  = D_REPEAT;
        unique case (act_q.mode)
            VM_WAIT:  dec = flag_q ? D_BRANCH : D_REPEAT;
            VM_EARLY: dec = flag_q ? D_BRANCH : (last ? D_ADVANCE : D_REPEAT);
            VM_NEXT:  dec = last ? D_ADVANCE : D_REPEAT;
            VM_STOP:  dec = last ? D_HALT : D_REPEAT;
            default:  dec = D_REPEAT;
        endcase
        if (st_q == S_IDLE) begin
            fetch_addr_o = start_addr_i;
        end else if (dec == D_BRANCH) begin
            fetch_addr_o = act_q.dest;
        end else begin
            fetch_addr_o = step_addr(addr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            act_q  <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (start_i) begin
                        addr_q <= fetch_addr_o;
                        act_q  <= fetch_ent_i;
                        rem_q  <= fetch_ent_i.reps;
                        st_q   <= S_START;
                    end
                end
                S_START: begin
                    st_q <= S_WAIT;
                end
                S_WAIT: begin
                    if (vd_s && sens) begin
                        flag_q <= 1'b1;
                    end
                    if (lt_done_i) begin
                        st_q <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    flag_q <= 1'b0;
                    unique case (dec)
                        D_REPEAT: begin
                            if (!last) begin
                                rem_q <= rem_q - FT_CNT_W'(1);
                            end
                            st_q <= S_START;
                        end
                        D_BRANCH, D_ADVANCE: begin
                            addr_q <= fetch_addr_o;
                            act_q  <= fetch_ent_i;
                            rem_q  <= fetch_ent_i.reps;
                            st_q   <= S_START;
                        end
                        default: begin
                            act_q <= '0;
                            st_q  <= S_IDLE;
                        end
                    endcase
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign state_o    = st_q;
    assign act_o      = act_q;
    assign vd_flag_o  = flag_q;
    assign lt_start_o = (st_q == S_START);

endmodule

// File: rtl/ftab_gate.sv
module ftab_gate
    import ftab_pkg::*;
(
    input  ft_entry_t act,
    input  logic      clpob_i,
    input  logic      clpdm_i,
    input  logic      pblk_i,
    output ctl_out_t  ctl
);

    always_comb begin
        ctl.clpob   = act.ob_en & clpob_i;
        ctl.clpdm   = act.dm_en & clpdm_i;
        ctl.pblk    = act.pb_en ? pblk_i : act.pb_idle;
        ctl.afe_clk = act.afe_en;
        ctl.amp     = act.amp_on;
    end

endmodule

// File: rtl/ftab_seq.sv
module ftab_seq
    import ftab_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tbl_wr_i,
    input  logic [FT_ADDR_W-1:0]  tbl_waddr_i,
    input  logic [FT_ENTRY_W-1:0] tbl_wdata_i,
    input  logic                  start_i,
    input  logic [FT_ADDR_W-1:0]  start_addr_i,
    input  logic                  vd_i,
    input  logic                  lt_done_i,
    output logic                  lt_start_o,
    output logic [FT_SEL_W-1:0]   lt_sel_o,
    input  logic                  clpob_i,
    input  logic                  clpdm_i,
    input  logic                  pblk_i,
    output logic                  clpob_o,
    output logic                  clpdm_o,
    output logic                  pblk_o,
    output logic                  afe_clk_en_o,
    output logic                  amp_en_o
);

    logic [FT_ADDR_W-1:0] fetch_addr;
    ft_entry_t            fetch_ent;
    ft_entry_t            act_w;
    seq_state_e           st_w;
    logic                 flag_w;
    logic                 vd_s;
    ctl_out_t             ctl_w;

    ftab_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (tbl_wr_i),
        .wr_addr (tbl_waddr_i),
        .wr_data (ft_entry_t'(tbl_wdata_i)),
        .rd_addr (fetch_addr),
        .rd_data (fetch_ent)
    );

    ftab_vdsync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .vd_i (vd_i),
        .vd_s (vd_s)
    );

    ftab_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .start_addr_i (start_addr_i),
        .lt_done_i    (lt_done_i),
        .vd_s         (vd_s),
        .fetch_addr_o (fetch_addr),
        .fetch_ent_i  (fetch_ent),
        .state_o      (st_w),
        .act_o        (act_w),
        .vd_flag_o    (flag_w),
        .lt_start_o   (lt_start_o)
    );

    ftab_gate u_gate (
        .act     (act_w),
        .clpob_i (clpob_i),
        .clpdm_i (clpdm_i),
        .pblk_i  (pblk_i),
        .ctl     (ctl_w)
    );

    assign lt_sel_o     = act_w.sel;
    assign clpob_o      = ctl_w.clpob;
    assign clpdm_o      = ctl_w.clpdm;
    assign pblk_o       = ctl_w.pblk;
    assign afe_clk_en_o = ctl_w.afe_clk;
    assign amp_en_o     = ctl_w.amp;

endmodule

// File: rtl/ftab_seq_chk.sv
module ftab_seq_chk
    import ftab_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       lt_done_i,
    input logic       lt_start_o,
    input logic       clpob_i,
    input logic       clpob_o,
    input logic       pblk_o,
    input logic       afe_clk_en_o,
    input logic       amp_en_o,
    input seq_state_e state,
    input logic       vd_flag
);

    // R3: each line request is a single-cycle pulse
    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        lt_start_o |=> !lt_start_o);

    // R8: no new line request while the current line is unfinished
    a_r8_no_start_before_done: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && !lt_done_i) |=> !lt_start_o);

    // R8: the VD latch is dropped at every boundary
    a_r8_flag_dropped: assert property (@(posedge clk) disable iff (rst)
        (state == S_NEXT) |=> !vd_flag);

    // R13: start during a running line does not disturb the run
    a_r13_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (state == S_WAIT && start_i && !lt_done_i) |=> (state == S_WAIT));

    // R10: gated clamp never asserts without its source
    a_r10_clpob_needs_src: assert property (@(posedge clk) disable iff (rst)
        clpob_o |-> clpob_i);

    // R9: idle means every control output is low
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE) |-> !(amp_en_o || afe_clk_en_o || clpob_o || pblk_o));

endmodule

bind ftab_seq ftab_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .lt_done_i    (lt_done_i),
    .lt_start_o   (lt_start_o),
    .clpob_i      (clpob_i),
    .clpob_o      (clpob_o),
    .pblk_o       (pblk_o),
    .afe_clk_en_o (afe_clk_en_o),
    .amp_en_o     (amp_en_o),
    .state        (st_w),
    .vd_flag      (flag_w)
);

// File: tb/ftab_seq_tb_top.sv
`timescale 1ns/1ps
module ftab_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_wr_i = 1'b0;
    logic [3:0]  tbl_waddr_i = '0;
    logic [23:0] tbl_wdata_i = '0;
    logic        start_i = 1'b0;
    logic [3:0]  start_addr_i = '0;
    logic        vd_i = 1'b0;
    logic        lt_done_i = 1'b0;
    logic        clpob_i = 1'b0, clpdm_i = 1'b0, pblk_i = 1'b0;
    logic        lt_start_o;
    logic [3:0]  lt_sel_o;
    logic        clpob_o, clpdm_o, pblk_o, afe_clk_en_o, amp_en_o;

    always #2 clk = ~clk;

    ftab_seq dut_i (
        .clk(clk), .rst(rst), .tbl_wr_i(tbl_wr_i), .tbl_waddr_i(tbl_waddr_i),
        .tbl_wdata_i(tbl_wdata_i), .start_i(start_i), .start_addr_i(start_addr_i),
        .vd_i(vd_i), .lt_done_i(lt_done_i), .lt_start_o(lt_start_o), .lt_sel_o(lt_sel_o),
        .clpob_i(clpob_i), .clpdm_i(clpdm_i), .pblk_i(pblk_i), .clpob_o(clpob_o),
        .clpdm_o(clpdm_o), .pblk_o(pblk_o), .afe_clk_en_o(afe_clk_en_o), .amp_en_o(amp_en_o)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int line_len = 3;
    int ex_cnt = 0;
    int sel_cnt [16];
    int lfsr = 32'h1357;

    // reference model state
    int          m_st = 0;
    int          m_addr = 0;
    int          m_rem = 0;
    logic [23:0] m_act = '0;
    bit          m_flag = 0, m_s1 = 0, m_s2 = 0;
    logic [23:0] tbl_m [16];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model update on every clock
    always @(posedge clk) begin
        int n_st, n_addr, n_rem, mode;
        logic [23:0] n_act;
        bit n_flag, sens, last, br;
        if (rst) begin
            m_st = 0; m_addr = 0; m_rem = 0; m_act = '0;
            m_flag = 0; m_s1 = 0; m_s2 = 0;
            for (int i = 0; i < 16; i++) tbl_m[i] = '0;
        end else begin
            n_st = m_st; n_addr = m_addr; n_rem = m_rem; n_act = m_act; n_flag = m_flag;
            mode = int'(m_act[15:14]);
            sens = (mode == 1) || (mode == 2);
            last = (m_rem == 0);
            if (m_st == 0) begin
                if (start_i) begin
                    n_addr = int'(start_addr_i);
                    n_act = tbl_m[start_addr_i];
                    n_rem = int'(n_act[23:16]);
                    n_st = 1;
                end
            end else if (m_st == 1) begin
                n_st = 2;
            end else if (m_st == 2) begin
                if (m_s2 && sens) n_flag = 1;
                if (lt_done_i) n_st = 3;
            end else begin
                n_flag = 0;
                br = sens && m_flag;
                if (br || (last && (mode == 0 || mode == 2))) begin
                    n_addr = br ? int'(m_act[13:10]) : (m_addr + 1) % 16;
                    n_act = tbl_m[n_addr];
                    n_rem = int'(n_act[23:16]);
                    n_st = 1;
                end else if (last && mode == 3) begin
                    n_act = '0;
                    n_st = 0;
                end else begin
                    if (!last) n_rem = m_rem - 1;
                    n_st = 1;
                end
            end
            if (tbl_wr_i) tbl_m[tbl_waddr_i] = tbl_wdata_i;
            m_s2 = m_s1; m_s1 = vd_i;
            m_st = n_st; m_addr = n_addr; m_rem = n_rem; m_act = n_act; m_flag = n_flag;
        end
    end

    // line executor model and source toggling
    always @(negedge clk) begin
        lt_done_i <= 1'b0;
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
        clpob_i <= lfsr[0];
        clpdm_i <= lfsr[3];
        pblk_i  <= lfsr[6];
        if (rst) ex_cnt = 0;
        else if (ex_cnt > 0) begin
            ex_cnt--;
            if (ex_cnt == 0) lt_done_i <= 1'b1;
        end else if (lt_start_o) ex_cnt = line_len;
    end

    // compare against the model every cycle
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk("R3 lt_start_o", int'(lt_start_o), int'(m_st == 1));
            chk("R2 R4 lt_sel_o", int'(lt_sel_o), int'(m_act[9:6]));
            chk("R10 clpob_o", int'(clpob_o), int'(m_act[5] & clpob_i));
            chk("R10 clpdm_o", int'(clpdm_o), int'(m_act[4] & clpdm_i));
            chk("R11 pblk_o", int'(pblk_o), int'(m_act[3] ? pblk_i : m_act[2]));
            chk("R12 afe_clk_en_o", int'(afe_clk_en_o), int'(m_act[1]));
            chk("R12 amp_en_o", int'(amp_en_o), int'(m_act[0]));
            if (lt_start_o) sel_cnt[lt_sel_o]++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr_entry(input int a, input int reps, input int mode, input int dest,
                            input int sel, input logic [5:0] en);
        @(negedge clk);
        tbl_wr_i = 1'b1;
        tbl_waddr_i = 4'(a);
        tbl_wdata_i = {8'(reps), 2'(mode), 4'(dest), 4'(sel), en};
        @(negedge clk);
        tbl_wr_i = 1'b0;
    endtask

    task automatic clr_counts();
        for (int i = 0; i < 16; i++) sel_cnt[i] = 0;
    endtask

    task automatic run_from(input int a);
        @(negedge clk);
        start_i = 1'b1;
        start_addr_i = 4'(a);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (m_st != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic vd_pulse(input int n);
        vd_i = 1'b1;
        repeat (n) @(negedge clk);
        vd_i = 1'b0;
    endtask

    initial begin
        clr_counts();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R1: idle outputs after reset
        chk("R1 lt_start_o", int'(lt_start_o), 0);
        chk("R1 lt_sel_o", int'(lt_sel_o), 0);
        chk("R1 controls", int'({clpob_o, clpdm_o, pblk_o, afe_clk_en_o, amp_en_o}), 0);

        // enables: {ob, dm, pb_en, pb_idle, afe, amp}
        wr_entry(0, 2, 0, 0, 1, 6'b100010);
        wr_entry(1, 0, 1, 5, 2, 6'b000101);
        wr_entry(5, 3, 2, 8, 3, 6'b011010);
        wr_entry(6, 1, 3, 0, 4, 6'b111111);
        wr_entry(8, 0, 3, 0, 7, 6'b000100);
        wr_entry(15, 0, 0, 0, 9, 6'b010011);

        // Run A: preview loop broken by VD
        line_len = 3; clr_counts();
        run_from(0);
        while (sel_cnt[2] < 5) @(negedge clk);
        vd_pulse(2);
        wait_idle();
        chk("R4 three lines of entry 0", sel_cnt[1], 3);
        chk("R6 wait entry looped", int'(sel_cnt[2] >= 5), 1);
        chk("R7 early entry ran c+1 lines", sel_cnt[3], 4);
        chk("R9 stop entry ran c+1 lines", sel_cnt[4], 2);

        // Run B: short VD pulse inside a long line
        line_len = 6; clr_counts();
        run_from(5);
        while (sel_cnt[3] < 2) @(negedge clk);
        vd_pulse(2);
        wait_idle();
        chk("R8 pulse latched, line finished", sel_cnt[3], 2);
        chk("R7 jumped to destination", sel_cnt[7], 1);
        chk("R7 no fall-through", sel_cnt[4], 0);

        // Run C: VD held high; overwrite entry 8 first
        wr_entry(8, 0, 3, 0, 11, 6'b000100);
        line_len = 2; clr_counts();
        vd_i = 1'b1;
        run_from(0);
        wait_idle();
        vd_i = 1'b0;
        chk("R5 mode 0 ignores VD", sel_cnt[1], 3);
        chk("R6 wait entry jumps after one line", sel_cnt[2], 1);
        chk("R7 early entry jumps after one line", sel_cnt[3], 1);
        chk("R2 overwritten entry used", sel_cnt[11], 1);
        chk("R2 old entry gone", sel_cnt[7], 0);

        // Run D: wrap from 15 and start ignored while running
        line_len = 1; clr_counts();
        repeat (4) @(negedge clk);
        run_from(15);
        while (sel_cnt[2] < 1) @(negedge clk);
        start_i = 1'b1; start_addr_i = 4'd15;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        while (sel_cnt[2] < 3) @(negedge clk);
        vd_pulse(10);
        wait_idle();
        chk("R4 wrap 15 to 0", sel_cnt[1], 3);
        chk("R13 start ignored while busy", sel_cnt[9], 1);

        // R9: a new start is accepted after the stop entry
        clr_counts();
        run_from(6);
        wait_idle();
        chk("R9 restart after stop", sel_cnt[4], 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule